// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity Select

This block sits between a reference divider and a feedback divider in a synthesizer loop. It compares the reference pulse train with the feedback pulse train and produces two digital pump controls. Each control stays high for as long as its own input leads the other, so the pulse width measures the phase error in clock cycles. The analog charge pump and the loop filter lie outside the block and take these controls as their input.

Edges on both inputs are found synchronously on the sampling clock. A rising reference edge arms the lead side and a rising feedback edge arms the lag side. Once both sides are armed, both stay high together for a fixed overlap of `OVERLAP` cycles and then clear. This shared overlap removes the dead zone around zero error. Extra edges on an already armed side are absorbed, so the detector covers a full two-cycle range and can also tell which input has the higher frequency. A polarity input swaps the two controls at the output, which suits VCOs whose tuning slope is positive or negative. A lock flag reports a run of comparisons with small error.

Top module: `pfd_polarity`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `pump_up`, `pump_dn` and `locked` are 0.
- R2: A rising edge on `ref_in` (high now, low at the previous clock edge) arms the lead side one clock edge later. With `invert`=0 the lead side drives `pump_up`.
- R3: A rising edge on `fb_in` arms the lag side one clock edge later. With `invert`=0 the lag side drives `pump_dn`.
- R4: Once both sides are armed, both outputs stay high together for exactly `OVERLAP` cycles (default 2) and then go low together, unless a new edge arrives.
- R5: If the feedback edge comes k cycles after the reference edge, `pump_up` is high for k+`OVERLAP` cycles and `pump_dn` for `OVERLAP` cycles. The mirror case gives the mirror result.
- R6: A second reference edge that arrives while the lead side is still armed and the lag side is not has no effect. The lead side stays high until the feedback edge, and both outputs are low after the overlap.
- R7: With `invert`=1, `pump_up` carries the lag side and `pump_dn` carries the lead side. Pulse widths are otherwise unchanged.
- R8: `locked` goes to 1 after `LOCK_RUNS` (default 8) consecutive comparisons whose non-overlap width is at most `LOCK_TOL` (default 1) cycle. A comparison with a wider error returns `locked` to 0.
- R9: Coincident reference and feedback edges produce both outputs high for exactly `OVERLAP` cycles, with no single-side pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference pulse train from the reference divider |
| fb_in | input | 1 | Feedback pulse train from the N divider |
| invert | input | 1 | 1 swaps the up and down outputs |
| pump_up | output | 1 | Charge pump up control |
| pump_dn | output | 1 | Charge pump down control |
| locked | output | 1 | Small-error run complete |

## Verification
The assertions assume that `ref_in` and `fb_in` are already synchronous to `clk`. Every pulse must be low for at least one sample before it rises, so that each rising edge is seen as exactly one edge. The stimulus drives both inputs only at falling clock edges, uses single-cycle high pulses, and leaves idle gaps between comparisons. `invert` changes only while both outputs are low, so that a width measurement never mixes the two polarities.

// File: rtl/pfd_polarity.sv
module pfd_polarity #(
  parameter int OVERLAP   = 2,
  parameter int LOCK_RUNS = 8,
  parameter int LOCK_TOL  = 1,
  parameter int GAP_BITS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic invert,
  output logic pump_up,
  output logic pump_dn,
  output logic locked
);
  localparam int OVW  = $clog2(OVERLAP + 1);
  localparam int RUNW = $clog2(LOCK_RUNS + 1);
  localparam logic [GAP_BITS-1:0] GAP_MAX = '1;

  logic ref_q, fb_q;
  logic lead_st, lag_st;
  logic [OVW-1:0] ov_cnt;
  logic [GAP_BITS-1:0] gap_cnt;
  logic [RUNW-1:0] runs;

  always_ff @(posedge clk) begin
    ref_q <= ref_in;
    fb_q  <= fb_in;
  end

  wire ref_rise = ref_in & ~ref_q;
  wire fb_rise  = fb_in & ~fb_q;
  wire both     = lead_st & lag_st;
  wire clr      = both && (ov_cnt == OVW'(OVERLAP - 1));
  wire good     = gap_cnt <= GAP_BITS'(LOCK_TOL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_st <= 1'b0;
      lag_st  <= 1'b0;
      ov_cnt  <= '0;
      gap_cnt <= '0;
      runs    <= '0;
    end else begin
      lead_st <= (lead_st & ~clr) | ref_rise;
      lag_st  <= (lag_st & ~clr) | fb_rise;
      ov_cnt  <= (both && !clr) ? ov_cnt + 1'b1 : '0;
      if (clr)
        gap_cnt <= '0;
      else if ((lead_st ^ lag_st) && gap_cnt != GAP_MAX)
        gap_cnt <= gap_cnt + 1'b1;
      if (clr)
        runs <= !good ? '0 : (runs == RUNW'(LOCK_RUNS)) ? runs : runs + 1'b1;
    end
  end

  assign pump_up = invert ? lag_st : lead_st;
  assign pump_dn = invert ? lead_st : lag_st;
  assign locked  = runs == RUNW'(LOCK_RUNS);
endmodule

module pfd_polarity_chk #(
  parameter int OVERLAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ref_in,
  input logic fb_in,
  input logic invert,
  input logic pump_up,
  input logic pump_dn,
  input logic locked
);
  logic [7:0] both_run;
  always_ff @(posedge clk) begin
    if (!rst_n) both_run <= '0;
    else if (pump_up && pump_dn) both_run <= (both_run == 8'hFF) ? both_run : both_run + 1'b1;
    else both_run <= '0;
  end

  AST_REF_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_in && !$past(ref_in)) |=> (invert ? pump_dn : pump_up)); // R2
  AST_FB_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_in && !$past(fb_in)) |=> (invert ? pump_up : pump_dn)); // R3
  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |-> (both_run < 8'(OVERLAP))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up && !pump_dn && !(ref_in && !$past(ref_in)) && !(fb_in && !$past(fb_in)))
    |=> (!pump_up && !pump_dn)); // R6
  AST_LOCK_AT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pump_up && pump_dn)); // R8
endmodule

bind pfd_polarity pfd_polarity_chk #(.OVERLAP(OVERLAP)) u_chk (.*);

// File: tb/test_pfd_polarity.sv
module test_pfd_polarity;
  localparam int OV = 2;
  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, fb_in = 1'b0, invert = 1'b0;
  logic pump_up, pump_dn, locked;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pfd_polarity #(.OVERLAP(OV)) i_pfd_polarity (.*);

  // {invert, ref delay[3:0], fb delay[3:0], up width[4:0], dn width[4:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 4'd0, 4'd0, 5'd2,  5'd2},
    {1'b0, 4'd0, 4'd3, 5'd5,  5'd2},
    {1'b0, 4'd4, 4'd0, 5'd2,  5'd6},
    {1'b0, 4'd0, 4'd1, 5'd3,  5'd2},
    {1'b1, 4'd0, 4'd3, 5'd2,  5'd5},
    {1'b1, 4'd5, 4'd0, 5'd7,  5'd2},
    {1'b1, 4'd2, 4'd2, 5'd2,  5'd2},
    {1'b0, 4'd1, 4'd9, 5'd10, 5'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmp(input int rd, input int fd, input int rd2, output int upw, output int dnw);
    int last = (rd > fd ? rd : fd);
    if (rd2 > last) last = rd2;
    upw = 0; dnw = 0;
    for (int t = 0; t <= last + OV + 4; t++) begin
      @(negedge clk);
      upw += int'(pump_up);
      dnw += int'(pump_dn);
      ref_in = (t == rd) || (t == rd2);
      fb_in  = (t == fd);
    end
    @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int upw, dnw;
    repeat (3) @(negedge clk);
    check("R1 up in reset", int'(pump_up), 0);
    check("R1 dn in reset", int'(pump_dn), 0);
    check("R1 lock in reset", int'(locked), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 up after release", int'(pump_up), 0);

    for (int i = 0; i < 8; i++) begin
      string tag;
      invert = VEC[i][18];
      tag = (VEC[i][17:14] == VEC[i][13:10]) ? "R9" : (invert ? "R7" : "R5");
      run_cmp(int'(VEC[i][17:14]), int'(VEC[i][13:10]), -1, upw, dnw);
      check({tag, " up width"}, upw, int'(VEC[i][9:5]));
      check({tag, " dn width"}, dnw, int'(VEC[i][4:0]));
    end
    invert = 1'b0;

    // R2 and R3: one-cycle latency from edge to output
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk); ref_in = 1'b0;
    check("R2 up armed", int'(pump_up), 1);
    check("R3 dn not yet", int'(pump_dn), 0);
    fb_in = 1'b1;
    @(negedge clk); fb_in = 1'b0;
    check("R3 dn armed", int'(pump_dn), 1);
    check("R4 overlap both", int'(pump_up & pump_dn), 1);
    @(negedge clk);
    check("R4 overlap second cycle", int'(pump_up & pump_dn), 1);
    @(negedge clk);
    check("R4 cleared up", int'(pump_up), 0);
    check("R4 cleared dn", int'(pump_dn), 0);

    // R6: extra reference edge is absorbed
    run_cmp(0, 6, 3, upw, dnw);
    check("R6 up width", upw, 6 + OV);
    check("R6 dn width", dnw, OV);
    check("R6 idle after", int'(pump_up | pump_dn), 0);

    // R8: lock run
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    for (int i = 0; i < 7; i++) run_cmp(0, (i % 2), -1, upw, dnw);
    check("R8 not locked after 7", int'(locked), 0);
    run_cmp(1, 0, -1, upw, dnw);
    check("R8 locked after 8", int'(locked), 1);
    run_cmp(0, 0, -1, upw, dnw);
    check("R8 stays locked", int'(locked), 1);
    run_cmp(0, 2, -1, upw, dnw);
    check("R8 wide error unlocks", int'(locked), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule